// File: doc/BRIEF.md
# BCD Time-of-Day Alarm Comparator

This block keeps a small time-of-day counter: seconds, minutes, hours and day-of-month, each in packed BCD with tens in the upper nibble and units in the lower nibble. It also holds four alarm registers of the same shape. A one-cycle pulse on `tick_1hz` advances the counter by one second. In the cycle after each advance, the unit compares the new time against the alarm fields. Bit 7 of each alarm register is a per-field mask: 0 means the field takes part in the compare, 1 means it is ignored. When every unmasked field matches, an alarm flag is set. The flag can drive an interrupt.

Software reaches the unit through a byte-wide register window that occupies the highest 16 addresses of a larger address space. Reads of the time return a read copy instead of the live counters. The read copy follows the counters while it is free and can be frozen for a consistent multi-byte read. New time values are written into that copy under a write-enable bit and are loaded into the counters all at once when the enable is released. The same enable guards the oscillator-fail flag.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset:
  - the time reads 00:00:00 with day 01;
  - all four alarm registers read 0x00;
  - the control register (offset 0x0) reads 0x02, meaning only the oscillator-fail bit is set;
  - `irq` is 0.
- R2: Each `tick_1hz` pulse advances the live time by one second, counting in BCD:
  - seconds and minutes wrap from 59 to 00 and carry into the next field;
  - hours wrap from 23 to 00 and carry into the day;
  - the day counts from 01 up to 31 and then wraps to 01.
- R3: Alarm registers sit at offsets 0x1 (seconds), 0x2 (minutes), 0x3 (hours) and 0x4 (day). Bit 7 of each is its mask; a field with mask 0 matches only when bits 6:0 equal the same bits of the time, and a field with mask 1 always matches.
- R4: The alarm flag (control bit 0) is set in the cycle after a tick whose updated time matches on every field. With all four masks at 1, every tick sets it.
- R5: A read of the control register returns the flag and then clears it. If a set and a clearing read happen in the same cycle, the read returns the old value and the flag stays set.
- R6: `irq` is high exactly while the alarm flag is 1 and the interrupt-enable bit (control bit 2) is 1.
- R7: The window responds only when address bits above bit 3 are all ones.
  - The time is at offsets 0x5 (seconds), 0x6 (minutes), 0x7 (hours) and 0x8 (day).
  - Read data appears on `bus_rdata` one clock after the access.
  - Unmapped offsets, and all addresses outside the window, read 0x00; writes to them change nothing.
- R8: While the freeze bit (control bit 3) is 1, the time read copy does not follow the counters. After the bit is cleared, the copy again shows the live time.
- R9: Time writes while the write-enable bit (control bit 4) is 1 go into the read copy and are visible to reads at once. Writing the control register with bit 4 at 0 while it was 1 loads the copy into the live counters. Time writes while write-enable is 0 are ignored.
- R10: The oscillator-fail bit (control bit 1) is set by reset. A control write changes it only if write-enable was already 1 before that write.
- R11: While the oscillator-stop bit (control bit 5) is 1, ticks are ignored: time does not advance and the alarm flag is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_en | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Alarm interrupt, level |

## Verification
The hardest state to reach from the ports is the set of rollover boundaries, such as 23:59:59 to 00:00:00 and day 31 to 01. Reaching them by counting alone would take a day of ticks. The bench instead loads time values near each boundary through the write-enable path, and it also runs one long sweep of ticks across midnight. A second hard case is the collision of an alarm set with a clearing read in the same cycle. The bench gets there by placing the control read in the cycle directly after a tick, with all alarm fields masked. Alarm matching is swept over all sixteen mask settings against all sixteen match/mismatch patterns.

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq
);
  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_AL0  = 4'h1;
  localparam logic [3:0] OFF_AL3  = 4'h4;
  localparam logic [3:0] OFF_TM0  = 4'h5;
  localparam logic [3:0] OFF_TM3  = 4'h8;

  logic [3:0][7:0] tm_q, rc_q, al_q, tm_nx;
  logic af_q, osf_q, aie_q, frz_q, wen_q, stop_q, tick_q;
  logic [7:0] rd_val;
  logic match;

  wire [3:0] off     = bus_addr[3:0];
  wire       in_win  = bus_en && (&bus_addr[ADDR_W-1:4]);
  wire       wr_hit  = in_win && bus_wr;
  wire       rd_hit  = in_win && !bus_wr;
  wire       ctrl_wr = wr_hit && off == OFF_CTRL;
  wire       ctrl_rd = rd_hit && off == OFF_CTRL;
  wire       tick_go = tick_1hz && !stop_q;
  wire       load    = ctrl_wr && wen_q && !bus_wdata[4];

  function automatic logic [8:0] bcd_step(input logic [7:0] v, input logic [7:0] top,
                                          input logic [7:0] base);
    if (v == top)           return {1'b1, base};
    else if (v[3:0] == 4'd9) return {1'b0, v[7:4] + 4'd1, 4'd0};
    else                    return {1'b0, v + 8'd1};
  endfunction

  always_comb begin
    logic [8:0] s, m, h, d;
    s = bcd_step(tm_q[0], 8'h59, 8'h00);
    m = bcd_step(tm_q[1], 8'h59, 8'h00);
    h = bcd_step(tm_q[2], 8'h23, 8'h00);
    d = bcd_step(tm_q[3], 8'h31, 8'h01);
    tm_nx[0] = s[7:0];
    tm_nx[1] = s[8] ? m[7:0] : tm_q[1];
    tm_nx[2] = (s[8] && m[8]) ? h[7:0] : tm_q[2];
    tm_nx[3] = (s[8] && m[8] && h[8]) ? d[7:0] : tm_q[3];
  end

  always_comb begin
    match = 1'b1;
    for (int i = 0; i < 4; i++)
      match &= al_q[i][7] || (al_q[i][6:0] == tm_q[i][6:0]);
  end

  always_comb begin
    rd_val = 8'h00;
    if (off == OFF_CTRL)
      rd_val = {2'b00, stop_q, wen_q, frz_q, aie_q, osf_q, af_q};
    else if (off >= OFF_AL0 && off <= OFF_AL3)
      rd_val = al_q[off - OFF_AL0];
    else if (off >= OFF_TM0 && off <= OFF_TM3)
      rd_val = rc_q[off - OFF_TM0];
  end

  assign irq = af_q && aie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tm_q      <= {8'h01, 8'h00, 8'h00, 8'h00};
      rc_q      <= {8'h01, 8'h00, 8'h00, 8'h00};
      al_q      <= '0;
      af_q      <= 1'b0;
      osf_q     <= 1'b1;
      aie_q     <= 1'b0;
      frz_q     <= 1'b0;
      wen_q     <= 1'b0;
      stop_q    <= 1'b0;
      tick_q    <= 1'b0;
      bus_rdata <= 8'h00;
    end else begin
      bus_rdata <= rd_hit ? rd_val : 8'h00;
      tick_q    <= tick_go && !load;

      if (load)         tm_q <= rc_q;
      else if (tick_go) tm_q <= tm_nx;

      if (wen_q) begin
        if (wr_hit && off >= OFF_TM0 && off <= OFF_TM3)
          rc_q[off - OFF_TM0] <= bus_wdata;
      end else if (!frz_q) begin
        rc_q <= tm_q;
      end

      if (wr_hit && off >= OFF_AL0 && off <= OFF_AL3)
        al_q[off - OFF_AL0] <= bus_wdata;

      if (ctrl_wr) begin
        if (wen_q) osf_q <= bus_wdata[1];
        aie_q  <= bus_wdata[2];
        frz_q  <= bus_wdata[3];
        wen_q  <= bus_wdata[4];
        stop_q <= bus_wdata[5];
      end

      if (tick_q && match) af_q <= 1'b1;
      else if (ctrl_rd)    af_q <= 1'b0;
    end
  end

  a_r4_flag_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(af_q) |-> $past(tick_q));
  a_r5_flag_clears_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(af_q) |-> $past(ctrl_rd));
  a_r2_seconds_move: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_go && !load) |=> tm_q[0] != $past(tm_q[0]));
  a_r11_idle_time_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_go && !load) |=> $stable(tm_q));
  a_r8_frozen_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q && !wen_q) |=> $stable(rc_q));
  a_r10_osf_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(osf_q) |-> $past(wen_q));
endmodule

// File: tb/test_rtc_alarm_match.sv
module test_rtc_alarm_match;
  localparam int AW = 20;
  localparam logic [AW-1:0] TOPA = 20'hFFFF0;

  logic clk = 0, rst_n = 0, tick = 0, en = 0, wr = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = 0, rdata;
  logic irq;
  int checks = 0, failures = 0, cyc = 0;
  logic exp_osf = 1'b1;

  rtc_alarm_match #(.ADDR_W(AW)) i_rtc_alarm_match (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .bus_en(en), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [7:0] bcd(input int n);
    return 8'((n / 10) * 16 + (n % 10));
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bw_raw(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); en = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); en = 0; wr = 0;
  endtask
  task automatic br_raw(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); en = 1; wr = 0; addr = a;
    @(negedge clk); d = rdata; en = 0;
  endtask
  task automatic bw(input logic [3:0] o, input logic [7:0] d);
    bw_raw(TOPA | AW'(o), d);
  endtask
  task automatic br(input logic [3:0] o, output logic [7:0] d);
    br_raw(TOPA | AW'(o), d);
  endtask
  task automatic do_tick;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    @(negedge clk);
  endtask
  function automatic logic [7:0] cw(input logic aie, frz, wen, stop);
    return {2'b00, stop, wen, frz, aie, exp_osf, 1'b0};
  endfunction
  task automatic set_time(input logic [7:0] s, m, h, d, input logic aie);
    bw(0, cw(aie, 0, 1, 0));
    bw(5, s); bw(6, m); bw(7, h); bw(8, d);
    bw(0, cw(aie, 0, 0, 0));
  endtask

  initial begin
    logic [7:0] d;
    int sod, day;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    br(0, d); chk("R1 ctrl", d, 8'h02);
    for (int i = 1; i <= 4; i++) begin br(4'(i), d); chk("R1 alarm", d, 8'h00); end
    br(5, d); chk("R1 sec", d, 8'h00);
    br(6, d); chk("R1 min", d, 8'h00);
    br(7, d); chk("R1 hour", d, 8'h00);
    br(8, d); chk("R1 day", d, 8'h01);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R10 osf guarded by previous write-enable
    bw(0, 8'h00); br(0, d); chk("R10 osf kept", d, 8'h02);
    bw(0, 8'h10); bw(0, 8'h10); exp_osf = 0; bw(0, 8'h00);
    br(0, d); chk("R10 osf cleared", d, 8'h00);

    // R9 ignored write without enable, immediate copy with enable
    bw(5, 8'h33); br(5, d); chk("R9 ignored write", d, 8'h00);
    bw(0, cw(0, 0, 1, 0)); bw(5, 8'h42); br(5, d); chk("R9 copy write", d, 8'h42);
    bw(0, cw(0, 0, 0, 0)); do_tick; br(5, d); chk("R9 loaded live", d, 8'h43);

    // R7 window decode
    bw_raw(20'h7FFF1, 8'h55); br(1, d); chk("R7 outside write", d, 8'h00);
    br_raw(20'h7FFF5, d); chk("R7 outside read", d, 8'h00);
    bw(4'hC, 8'h77); br(4'hC, d); chk("R7 unmapped", d, 8'h00);

    // R8 freeze
    set_time(8'h10, 8'h00, 8'h00, 8'h01, 0);
    bw(0, cw(0, 1, 0, 0));
    repeat (4) do_tick;
    br(5, d); chk("R8 frozen", d, 8'h10);
    bw(0, cw(0, 0, 0, 0)); @(negedge clk);
    br(5, d); chk("R8 resumed", d, 8'h14);

    // R11 oscillator stop
    for (int i = 1; i <= 4; i++) bw(4'(i), 8'h80);
    br(0, d);
    bw(0, cw(0, 0, 0, 1));
    repeat (3) do_tick;
    br(5, d); chk("R11 no advance", d, 8'h14);
    br(0, d); chk("R11 no flag", d, cw(0, 0, 0, 1));
    bw(0, cw(0, 0, 0, 0));

    // R4 all masked fires every tick; R5 same-cycle set wins over read clear
    do_tick; br(0, d); chk("R4 all masked", d, 8'h01);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0; en = 1; wr = 0; addr = TOPA;
    @(negedge clk); d = rdata; en = 0;
    chk("R5 read returns old", d, 8'h00);
    br(0, d); chk("R5 set wins", d, 8'h01);
    br(0, d); chk("R5 cleared", d, 8'h00);

    // R2 hour rollovers
    for (int h = 0; h < 24; h++) begin
      set_time(8'h59, 8'h59, bcd(h), 8'h10, 0);
      do_tick;
      br(5, d); chk("R2 sec wrap", d, 8'h00);
      br(6, d); chk("R2 min wrap", d, 8'h00);
      br(7, d); chk("R2 hour carry", d, bcd((h + 1) % 24));
      br(8, d); chk("R2 day carry", d, h == 23 ? 8'h11 : 8'h10);
    end
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 0);
    do_tick; br(8, d); chk("R2 day 31 wraps", d, 8'h01);

    // R2 long sweep across midnight
    set_time(8'h00, 8'h00, 8'h23, 8'h30, 0);
    sod = 23 * 3600; day = 30;
    for (int t = 0; t < 3700; t++) begin
      do_tick;
      sod++;
      if (sod == 86400) begin sod = 0; day = (day == 31) ? 1 : day + 1; end
      br(5, d); chk("R2 sweep sec", d, bcd(sod % 60));
      if (sod % 60 == 0) begin
        br(6, d); chk("R2 sweep min", d, bcd((sod / 60) % 60));
        br(7, d); chk("R2 sweep hour", d, bcd(sod / 3600));
        br(8, d); chk("R2 sweep day", d, bcd(day));
      end
    end

    // R3 R4 R6 mask x pattern sweep; time after tick is 10:20:30 day 15
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 16; p++) begin
        logic [3:0][7:0] hitv, missv;
        logic aie, exp_af;
        hitv  = {8'h15, 8'h10, 8'h20, 8'h30};
        missv = {8'h16, 8'h11, 8'h21, 8'h31};
        aie = p[0] ^ m[1];
        exp_af = 1'b1;
        for (int f = 0; f < 4; f++) begin
          bw(4'(f + 1), {m[f], p[f] ? hitv[f][6:0] : missv[f][6:0]});
          if (!m[f] && !p[f]) exp_af = 1'b0;
        end
        set_time(8'h29, 8'h20, 8'h10, 8'h15, aie);
        br(0, d);
        do_tick;
        chk("R6 irq level", {7'd0, irq}, {7'd0, exp_af & aie});
        br(0, d); chk("R3 mask compare", d, {2'b00, 1'b0, 1'b0, 1'b0, aie, exp_osf, exp_af});
        chk("R5 irq after clear", {7'd0, irq}, 8'h00);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule